// File: doc/BRIEF.md
# H-Bridge Chopping Current Regulator

This block controls one H-bridge from two direction inputs. It caps the winding current by chopping at a fixed frequency. Each chopping period starts by driving the winding in the direction the inputs select. A blanking window then masks the current-sense comparator. After the window, the first trip from the comparator ends the drive phase. The bridge then decays the current until the period ends. The decay can be slow (both low sides on), fast (bridge reversed until a zero-current flag asserts, then all switches off) or mixed (fast decay that turns into slow decay at 75% of the period).

A 5-bit level code is translated into a 7-bit percentage. This value feeds an external reference DAC, which sets the trip threshold along a roughly sinusoidal curve. When both direction inputs are equal, chopping is suspended and the two bridge outputs sit at the same level.

The block is written for a parameterised clock, with 50 MHz as the default. At that frequency a period is 1000 clocks, the blanking window is 188 clocks, and the mixed-decay switch point is clock 750 of the period.

Top module: `hbridge_chopper`

## Requirements
- R1: While reset is asserted, all four gate enables are 0, even if the direction inputs are equal. `dac_pct` still follows `level_code`.
- R2: The first clock after reset release is cycle 0 of a period of 1000 clocks. In every period, drive is applied from cycle 0.
  - `dir_a`=1, `dir_b`=0 enables `leg_a_hi` and `leg_b_lo`.
  - `dir_a`=0, `dir_b`=1 enables `leg_b_hi` and `leg_a_lo`.
- R3: The comparator is ignored while the period counter is below 187. Drive therefore lasts at least 188 clocks, even if `trip` is high from cycle 0.
- R4: When `trip` is seen high at a counter value of 187 or more, drive stops on the next clock. Decay then continues until the period ends.
- R5: With `decay_sel`=00 (slow), decay enables `leg_a_lo` and `leg_b_lo` only.
- R6: With `decay_sel`=10 (fast), decay enables the reversed drive pair. When `zero_cur` is seen high, all four enables go to 0 on the next clock and stay 0 for the rest of the period.
- R7: `decay_sel`=01 and 11 both select mixed decay.
  - Mixed decay behaves as fast decay (including the zero-current turn-off) while the counter is below 749.
  - From counter value 750 to the end of the period, mixed decay enables both low sides.
  - A trip seen at a counter value of 749 or more goes straight to slow decay.
- R8: When `dir_a`==`dir_b`, chopping is suspended and `trip` is ignored.
  - 00 enables both low sides.
  - 11 enables both high sides.
- R9: `leg_a_hi` and `leg_a_lo` are never both 1 in the same cycle, and neither are `leg_b_hi` and `leg_b_lo`.
- R10: `dac_pct` maps codes 0..31, in the same cycle, to 0,5,10,15,20,24,29,34,38,43,47,51,56,60,63,67,71,74,77,80,83,86,88,90,92,94,96,97,98,99,100,100.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| dir_a | input | 1 | Direction input for leg A |
| dir_b | input | 1 | Direction input for leg B |
| level_code | input | 5 | Current level code |
| trip | input | 1 | Synchronised current-sense comparator flag |
| zero_cur | input | 1 | Winding current has reached zero |
| decay_sel | input | 2 | Decay mode: 00 slow, 01/11 mixed, 10 fast |
| leg_a_hi | output | 1 | Leg A high-side gate enable |
| leg_a_lo | output | 1 | Leg A low-side gate enable |
| leg_b_hi | output | 1 | Leg B high-side gate enable |
| leg_b_lo | output | 1 | Leg B low-side gate enable |
| dac_pct | output | 7 | Trip level in percent of full scale |

## Verification
The assertions check the following on every cycle:
- no leg ever enables both of its switches;
- the phase is drive throughout the blanking window;
- a period wrap always restarts drive;
- fast decay leaves its reversed state once the zero flag is seen;
- mixed decay is slow after the 75% point;
- the top two level codes give full scale.

Only the bench's scenarios can show the other behaviours, because they depend on which gate pair is active at a given cycle:
- trips landing exactly on the first unmasked cycle;
- the fast-then-off-then-slow sequence of mixed decay;
- direction changes in the middle of a period;
- equal inputs overriding a pending trip.

// File: rtl/chop_pkg.sv
package chop_pkg;

   typedef enum logic [1:0] {
      PH_DRIVE = 2'd0,
      PH_FAST  = 2'd1,
      PH_SLOW  = 2'd2,
      PH_OFF   = 2'd3
   } phase_t;

   typedef enum logic [1:0] {
      MODE_SLOW  = 2'd0,
      MODE_MIXED = 2'd1,
      MODE_FAST  = 2'd2
   } decay_mode_t;

   // 00 slow, 10 fast, 01 and 11 mixed
   function automatic decay_mode_t decode_mode(input logic [1:0] sel);
      case (sel)
         2'b00:   return MODE_SLOW;
         2'b10:   return MODE_FAST;
         default: return MODE_MIXED;
      endcase
   endfunction

   // near-sinusoidal percentage curve for the trip reference
   function automatic logic [6:0] level_to_pct(input logic [4:0] code);
      case (code)
         5'd0:  return 7'd0;   5'd1:  return 7'd5;
         5'd2:  return 7'd10;  5'd3:  return 7'd15;
         5'd4:  return 7'd20;  5'd5:  return 7'd24;
         5'd6:  return 7'd29;  5'd7:  return 7'd34;
         5'd8:  return 7'd38;  5'd9:  return 7'd43;
         5'd10: return 7'd47;  5'd11: return 7'd51;
         5'd12: return 7'd56;  5'd13: return 7'd60;
         5'd14: return 7'd63;  5'd15: return 7'd67;
         5'd16: return 7'd71;  5'd17: return 7'd74;
         5'd18: return 7'd77;  5'd19: return 7'd80;
         5'd20: return 7'd83;  5'd21: return 7'd86;
         5'd22: return 7'd88;  5'd23: return 7'd90;
         5'd24: return 7'd92;  5'd25: return 7'd94;
         5'd26: return 7'd96;  5'd27: return 7'd97;
         5'd28: return 7'd98;  5'd29: return 7'd99;
         default: return 7'd100;
      endcase
   endfunction

endpackage

// File: rtl/chop_timer.sv
module chop_timer #(
   parameter int PERIOD_CLKS = 1000,
   parameter int BLANK_CLKS  = 188,
   parameter int MIX_CLKS    = 750,
   localparam int CW = $clog2(PERIOD_CLKS)
) (
   input  logic          clk,
   input  logic          rst_n,
   output logic          live,
   output logic          period_end,
   output logic          blank_done,
   output logic          mix_late,
   output logic [CW-1:0] cnt
);

   localparam logic [CW-1:0] LAST      = CW'(PERIOD_CLKS - 1);
   localparam logic [CW-1:0] BLANK_END = CW'(BLANK_CLKS - 1);
   localparam logic [CW-1:0] MIX_EDGE  = CW'(MIX_CLKS - 1);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt  <= LAST;
         live <= 1'b0;
      end else begin
         live <= 1'b1;
         cnt  <= (cnt == LAST) ? '0 : cnt + 1'b1;
      end
   end

   assign period_end = (cnt == LAST);
   assign blank_done = (cnt >= BLANK_END);
   assign mix_late   = (cnt >= MIX_EDGE);

   // R2
   cnt_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cnt == LAST) |=> (cnt == '0));

   // R2
   cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cnt <= LAST);

endmodule

// File: rtl/chop_phase.sv
module chop_phase
   import chop_pkg::*;
(
   input  logic        clk,
   input  logic        rst_n,
   input  logic        active,
   input  logic        period_end,
   input  logic        blank_done,
   input  logic        mix_late,
   input  logic        trip,
   input  logic        zero_cur,
   input  decay_mode_t mode,
   output phase_t      phase
);

   phase_t nxt;

   always_comb begin
      nxt = phase;
      if (!active || period_end) begin
         nxt = PH_DRIVE;
      end else begin
         case (phase)
            PH_DRIVE: if (trip && blank_done) begin
               case (mode)
                  MODE_SLOW: nxt = PH_SLOW;
                  MODE_FAST: nxt = PH_FAST;
                  default:   nxt = mix_late ? PH_SLOW : PH_FAST;
               endcase
            end
            PH_FAST: begin
               if (mode == MODE_MIXED && mix_late) nxt = PH_SLOW;
               else if (zero_cur)                  nxt = PH_OFF;
            end
            PH_OFF:  if (mode == MODE_MIXED && mix_late) nxt = PH_SLOW;
            default: nxt = phase;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) phase <= PH_OFF;
      else        phase <= nxt;
   end

   // R6
   fast_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (phase == PH_FAST && zero_cur && !(mode == MODE_MIXED && mix_late))
      |=> (phase != PH_FAST));

   // R7
   mix_slow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (active && !period_end && mode == MODE_MIXED && mix_late &&
       (phase == PH_FAST || phase == PH_OFF)) |=> (phase == PH_SLOW));

endmodule

// File: rtl/chop_gates.sv
module chop_gates
   import chop_pkg::*;
(
   input  logic   live,
   input  logic   dir_a,
   input  logic   dir_b,
   input  phase_t phase,
   output logic   a_hi,
   output logic   a_lo,
   output logic   b_hi,
   output logic   b_lo
);

   always_comb begin
      {a_hi, a_lo, b_hi, b_lo} = 4'b0000;
      if (live) begin
         if (dir_a == dir_b) begin
            {a_hi, a_lo, b_hi, b_lo} = dir_a ? 4'b1010 : 4'b0101;
         end else begin
            case (phase)
               PH_DRIVE: {a_hi, a_lo, b_hi, b_lo} = dir_a ? 4'b1001 : 4'b0110;
               PH_FAST:  {a_hi, a_lo, b_hi, b_lo} = dir_a ? 4'b0110 : 4'b1001;
               PH_SLOW:  {a_hi, a_lo, b_hi, b_lo} = 4'b0101;
               default:  {a_hi, a_lo, b_hi, b_lo} = 4'b0000;
            endcase
         end
      end
   end

endmodule

// File: rtl/hbridge_chopper.sv
module hbridge_chopper
   import chop_pkg::*;
#(
   parameter int CLK_HZ   = 50_000_000,
   parameter int CHOP_HZ  = 50_000,
   parameter int BLANK_NS = 3750,
   parameter int MIX_PCT  = 75,
   parameter bit DAC_REG  = 1'b0
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       dir_a,
   input  logic       dir_b,
   input  logic [4:0] level_code,
   input  logic       trip,
   input  logic       zero_cur,
   input  logic [1:0] decay_sel,
   output logic       leg_a_hi,
   output logic       leg_a_lo,
   output logic       leg_b_hi,
   output logic       leg_b_lo,
   output logic [6:0] dac_pct
);

   localparam int    PERIOD_CLKS = CLK_HZ / CHOP_HZ;
   localparam longint BLANK_L    =
      (longint'(CLK_HZ) * longint'(BLANK_NS) + 64'd999_999_999) / 64'd1_000_000_000;
   localparam int    BLANK_CLKS  = int'(BLANK_L);
   localparam int    MIX_CLKS    = (PERIOD_CLKS * MIX_PCT) / 100;
   localparam int    CW          = $clog2(PERIOD_CLKS);

   if (PERIOD_CLKS < 8) begin : g_bad_period
      $error("chopping period too short for the clock");
   end
   if (MIX_PCT < 1 || MIX_PCT > 99) begin : g_bad_mix
      $error("mixed switch point must be inside the period");
   end
   if (BLANK_CLKS < 2 || BLANK_CLKS >= MIX_CLKS) begin : g_bad_blank
      $error("blanking window must end before the mixed switch point");
   end

   logic          live, period_end, blank_done, mix_late;
   logic [CW-1:0] cnt;
   phase_t        phase;
   decay_mode_t   mode;
   logic          active;

   assign mode   = decode_mode(decay_sel);
   assign active = dir_a ^ dir_b;

   chop_timer #(
      .PERIOD_CLKS(PERIOD_CLKS),
      .BLANK_CLKS (BLANK_CLKS),
      .MIX_CLKS   (MIX_CLKS)
   ) u_timer (
      .clk       (clk),
      .rst_n     (rst_n),
      .live      (live),
      .period_end(period_end),
      .blank_done(blank_done),
      .mix_late  (mix_late),
      .cnt       (cnt)
   );

   chop_phase u_phase (
      .clk       (clk),
      .rst_n     (rst_n),
      .active    (active),
      .period_end(period_end),
      .blank_done(blank_done),
      .mix_late  (mix_late),
      .trip      (trip),
      .zero_cur  (zero_cur),
      .mode      (mode),
      .phase     (phase)
   );

   chop_gates u_gates (
      .live (live),
      .dir_a(dir_a),
      .dir_b(dir_b),
      .phase(phase),
      .a_hi (leg_a_hi),
      .a_lo (leg_a_lo),
      .b_hi (leg_b_hi),
      .b_lo (leg_b_lo)
   );

   if (DAC_REG) begin : g_dac_reg
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) dac_pct <= '0;
         else        dac_pct <= level_to_pct(level_code);
      end
   end else begin : g_dac_comb
      assign dac_pct = level_to_pct(level_code);

      // R10
      full_scale_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (level_code >= 5'd30) |-> (dac_pct == 7'd100));
   end

   // R9
   no_shoot_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(leg_a_hi && leg_a_lo) && !(leg_b_hi && leg_b_lo));

   // R3
   blank_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (live && !blank_done) |-> (phase == PH_DRIVE));

   // R2
   wrap_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
      period_end |=> (phase == PH_DRIVE));

endmodule

// File: tb/sim_hbridge_chopper.sv
module sim_hbridge_chopper;

   localparam int CLK_PERIOD = 10;
   localparam int PER   = 1000;
   localparam int BLK   = 188;
   localparam int MIXP  = 750;
   localparam int NEVER = 5000;

   localparam int S_DRIVE = 0, S_FAST = 1, S_SLOW = 2, S_OFF = 3;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic dir_a = 1'b1, dir_b = 1'b1;
   logic [4:0] level_code = 5'd12;
   logic trip = 1'b0, zero_cur = 1'b0;
   logic [1:0] decay_sel = 2'b00;
   logic leg_a_hi, leg_a_lo, leg_b_hi, leg_b_lo;
   logic [6:0] dac_pct;

   int checks = 0;
   int errors = 0;
   int cyc = 0;
   bit done = 1'b0;
   int mcnt = PER - 1;
   int mst  = S_OFF;

   always #(CLK_PERIOD/2) clk = ~clk;

   hbridge_chopper u0 (
      .clk(clk), .rst_n(rst_n), .dir_a(dir_a), .dir_b(dir_b),
      .level_code(level_code), .trip(trip), .zero_cur(zero_cur),
      .decay_sel(decay_sel), .leg_a_hi(leg_a_hi), .leg_a_lo(leg_a_lo),
      .leg_b_hi(leg_b_hi), .leg_b_lo(leg_b_lo), .dac_pct(dac_pct)
   );

   function automatic int exp_pct(input int c);
      case (c)
         0: return 0;   1: return 5;   2: return 10;  3: return 15;
         4: return 20;  5: return 24;  6: return 29;  7: return 34;
         8: return 38;  9: return 43;  10: return 47; 11: return 51;
         12: return 56; 13: return 60; 14: return 63; 15: return 67;
         16: return 71; 17: return 74; 18: return 77; 19: return 80;
         20: return 83; 21: return 86; 22: return 88; 23: return 90;
         24: return 92; 25: return 94; 26: return 96; 27: return 97;
         28: return 98; 29: return 99; default: return 100;
      endcase
   endfunction

   function automatic bit is_mixed(input logic [1:0] s);
      return (s == 2'b01) || (s == 2'b11);
   endfunction

   // expected {a_hi, a_lo, b_hi, b_lo}
   function automatic logic [3:0] exp_gates(input logic a, input logic b, input int st);
      if (a == b) return a ? 4'b1010 : 4'b0101;
      case (st)
         S_DRIVE: return a ? 4'b1001 : 4'b0110;
         S_FAST:  return a ? 4'b0110 : 4'b1001;
         S_SLOW:  return 4'b0101;
         default: return 4'b0000;
      endcase
   endfunction

   function automatic string tag_of(input logic a, input logic b, input int st,
                                    input int c, input logic [1:0] s);
      if (a == b) return "R8";
      case (st)
         S_DRIVE: return (c < BLK) ? "R3" : "R2";
         S_FAST:  return is_mixed(s) ? "R7" : "R6";
         S_SLOW:  return is_mixed(s) ? "R7" : "R4 R5";
         default: return is_mixed(s) ? "R7" : "R6";
      endcase
   endfunction

   task automatic check4(input string req, input logic [3:0] act, input logic [3:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s cycle %0d: gates %b expected %b", req, mcnt, act, exp);
      end
   endtask

   task automatic check_int(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s: got %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic finish_up;
      if (!done) begin
         done = 1'b1;
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   endtask

   // reference model of the period and decay behaviour
   always @(posedge clk) begin
      if (!rst_n) begin
         mcnt = PER - 1;
         mst  = S_OFF;
      end else begin
         if (dir_a == dir_b || mcnt == PER - 1) begin
            mst = S_DRIVE;
         end else begin
            case (mst)
               S_DRIVE: if (trip && mcnt >= BLK - 1) begin
                  if (decay_sel == 2'b00)      mst = S_SLOW;
                  else if (decay_sel == 2'b10) mst = S_FAST;
                  else                         mst = (mcnt >= MIXP - 1) ? S_SLOW : S_FAST;
               end
               S_FAST: begin
                  if (is_mixed(decay_sel) && mcnt >= MIXP - 1) mst = S_SLOW;
                  else if (zero_cur)                           mst = S_OFF;
               end
               S_OFF: if (is_mixed(decay_sel) && mcnt >= MIXP - 1) mst = S_SLOW;
               default: ;
            endcase
         end
         mcnt = (mcnt == PER - 1) ? 0 : mcnt + 1;
      end
   end

   // per-cycle comparison, away from both clock edges
   always @(posedge clk) begin
      #3;
      if (rst_n && !done) begin
         check4(tag_of(dir_a, dir_b, mst, mcnt, decay_sel),
                {leg_a_hi, leg_a_lo, leg_b_hi, leg_b_lo},
                exp_gates(dir_a, dir_b, mst));
         // R9 no leg has both switches on
         checks++;
         if ((leg_a_hi && leg_a_lo) || (leg_b_hi && leg_b_lo)) begin
            errors++;
            $display("FAIL R9 cycle %0d: gates %b expected no leg with both on",
                     mcnt, {leg_a_hi, leg_a_lo, leg_b_hi, leg_b_lo});
         end
      end
   end

   // watchdog
   always @(posedge clk) begin
      cyc++;
      if (cyc > 120000 && !done) begin
         errors++;
         $display("FAIL watchdog: got %0d cycles expected fewer", cyc);
         finish_up();
      end
   end

   task automatic run_period(input logic a, input logic b, input logic [1:0] sel,
                             input int trip_at, input int zero_at, input logic [4:0] code,
                             input int flip_at, input logic a2, input logic b2);
      while (mcnt != PER - 1) @(negedge clk);
      dir_a = a; dir_b = b; decay_sel = sel; level_code = code;
      trip = 1'b0; zero_cur = 1'b0;
      for (int k = 0; k < PER; k++) begin
         @(negedge clk);
         trip     = (mcnt >= trip_at);
         zero_cur = (mcnt >= zero_at);
         if (mcnt == flip_at) begin
            dir_a = a2; dir_b = b2;
         end
         #1;
         // R10 DAC follows the code in the same cycle
         if (k == 5) check_int("R10", int'(dac_pct), exp_pct(int'(code)));
      end
   endtask

   initial begin
      int unsigned s;
      s = $urandom(32'd2718);
      // R1 reset state with equal inputs that would otherwise drive
      repeat (3) @(negedge clk);
      check4("R1", {leg_a_hi, leg_a_lo, leg_b_hi, leg_b_lo}, 4'b0000);
      check_int("R1", int'(dac_pct), 56);
      dir_a = 1'b0; dir_b = 1'b0;
      @(negedge clk);
      check4("R1", {leg_a_hi, leg_a_lo, leg_b_hi, leg_b_lo}, 4'b0000);
      rst_n = 1'b1;

      // R10 full table sweep
      for (int c = 0; c < 32; c++) begin
         @(negedge clk);
         level_code = 5'(c);
         #1 check_int("R10", int'(dac_pct), exp_pct(c));
      end

      // directed corner cases
      run_period(1, 0, 2'b00, 0,    NEVER, 5'd31, NEVER, 0, 0); // R3 trip held from cycle 0
      run_period(0, 1, 2'b00, 500,  NEVER, 5'd30, NEVER, 0, 0); // R4 R5
      run_period(1, 0, 2'b10, 300,  450,   5'd10, NEVER, 0, 0); // R6
      run_period(0, 1, 2'b10, 187,  NEVER, 5'd3,  NEVER, 0, 0); // R3 first unmasked cycle
      run_period(1, 0, 2'b10, 186,  600,   5'd4,  NEVER, 0, 0); // R3 one before
      run_period(1, 0, 2'b01, 300,  500,   5'd20, NEVER, 0, 0); // R7 fast, off, slow
      run_period(0, 1, 2'b11, 800,  900,   5'd21, NEVER, 0, 0); // R7 late trip, code 11
      run_period(1, 0, 2'b01, 200,  NEVER, 5'd22, NEVER, 0, 0); // R7 fast to slow
      run_period(0, 1, 2'b01, 749,  NEVER, 5'd23, NEVER, 0, 0); // R7 trip at switch edge
      run_period(0, 0, 2'b00, 0,    NEVER, 5'd1,  NEVER, 0, 0); // R8 both low
      run_period(1, 1, 2'b10, 0,    0,     5'd2,  NEVER, 0, 0); // R8 both high
      run_period(1, 0, 2'b00, 300,  NEVER, 5'd8,  400,   0, 1); // R2 direction flip
      run_period(1, 0, 2'b01, 200,  NEVER, 5'd9,  500,   1, 1); // R8 mid-period equal

      // constrained random periods
      for (int p = 0; p < 14; p++) begin
         logic ra, rb;
         int tr, zr;
         ra = 1'($urandom);
         rb = ($urandom % 4 == 0) ? ra : ~ra;
         tr = $urandom % 1100;
         zr = tr + ($urandom % 700);
         run_period(ra, rb, 2'($urandom), tr, zr, 5'($urandom), NEVER, 0, 0);
      end

      repeat (4) @(negedge clk);
      finish_up();
   end

endmodule